// File: doc/BRIEF.md
# Bidirectional GPIO port controller

This block manages an 8-bit bidirectional I/O port on a chip. Software sees four word-wide registers on a simple write/read bus. The first is a port view, which reads the pin levels and writes the output latch. The second is the output latch. The third is a direction mask, and the fourth is a configuration word that holds a global weak pull-up enable. The block drives a per-pin output value, output enable and pull-up enable to the pad ring. It also takes the pad input levels through a two-flop synchronizer.

Two other owners can take over the pins. An external multiplexed address/data bus always wins when it is enabled. A parallel slave port wins over plain GPIO when its mode is on and the external bus is off. The block also drives a buffer-type select. This select asks the pads for TTL thresholds while the parallel port owns the pins and for Schmitt thresholds at all other times.

Top module: `bport`

## Requirements
- R1: After any reset, every direction bit is 1, so the block drives padOe to all zeros. The latch resets to zero. The global pull-up enable is 1, so padPullupEn is all ones while GPIO owns the pins.
- R2: In GPIO ownership, a direction bit of 1 drives padOe low for that pin. A direction bit of 0 drives padOe high and puts the latch bit on padOut. A register write takes effect on the next clock edge.
- R3: A read at address 1 returns the latch contents, not the pin levels.
- R4: A read at address 0 returns padIn as sampled two clock edges earlier, through two synchronizer flops that reset to zero.
- R5: A write at address 0 loads the output latch, the same as a write at address 1.
- R6: Bit 0 of the configuration register at address 3 is the global pull-up enable, active high. When it is cleared, padPullupEn is all zeros.
- R7: padPullupEn is 0 for every pin whose padOe is 1, in every ownership mode.
- R8: While extBusEn is 1, padOut equals extOut and padOe equals extOe. The parallel port mode and the GPIO registers then have no effect on the pins.
- R9: While pspMode is 1 and extBusEn is 0, padOut equals pspOut and padOe equals pspOe.
- R10: ttlSel is 1 exactly when the parallel port owns the pins (pspMode is 1 and extBusEn is 0). Otherwise it is 0, which selects Schmitt thresholds.
- R11: A read at address 2 returns the direction register. A read at address 3 returns the pull-up enable in bit 0 and zeros in bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address (0 port, 1 latch, 2 direction, 3 config) |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| extBusEn | input | 1 | External address/data bus owns the pins |
| extOut | input | 8 | External bus output value |
| extOe | input | 8 | External bus output enable per pin |
| pspMode | input | 1 | Parallel slave port mode |
| pspOut | input | 8 | Parallel port output value |
| pspOe | input | 8 | Parallel port output enable per pin |
| padIn | input | 8 | Pad input levels, asynchronous |
| padOut | output | 8 | Pad output value |
| padOe | output | 8 | Pad output enable, 1 drives the pin |
| padPullupEn | output | 8 | Weak pull-up enable per pin |
| ttlSel | output | 1 | 1 selects TTL input thresholds, 0 selects Schmitt |

## Verification
The assertions check several properties on every cycle: the ownership priority at the pads, the rule that a driven pin never has its pull-up on, the TTL select, and the two-cycle delay of the port read. They also check that a direction write shows up on padOe one edge later and that the pads come out of reset as inputs with pull-ups on. Other behaviours can only be shown by the bench's scenarios. These are the latch readback while the pins carry other levels, a port-address write landing in the latch, the global pull-up clear, and the direction and config readback values.

// File: rtl/bport_pkg.sv
package bport_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_PORT = 2'd0;
  localparam logic [ADDR_W-1:0] REG_LAT  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_DIR  = 2'd2;
  localparam logic [ADDR_W-1:0] REG_CFG  = 2'd3;

  typedef enum logic [1:0] {RD_PORT, RD_LAT, RD_DIR, RD_CFG} rdSel_e;

  typedef struct packed {
    logic   wrLat;
    logic   wrDir;
    logic   wrCfg;
    logic   selExt;
    logic   selPsp;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/bport_ctrl.sv
module bport_ctrl
  import bport_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              extBusEn,
  input  logic              pspMode,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    stb.selExt = extBusEn;
    stb.selPsp = pspMode & ~extBusEn;
    unique case (busAddr)
      REG_PORT: begin stb.wrLat = busWrEn; stb.rdSel = RD_PORT; end
      REG_LAT:  begin stb.wrLat = busWrEn; stb.rdSel = RD_LAT;  end
      REG_DIR:  begin stb.wrDir = busWrEn; stb.rdSel = RD_DIR;  end
      default:  begin stb.wrCfg = busWrEn; stb.rdSel = RD_CFG;  end
    endcase
  end
endmodule

// File: rtl/bport_dpath.sv
module bport_dpath
  import bport_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] extOut,
  input  logic [WIDTH-1:0] extOe,
  input  logic [WIDTH-1:0] pspOut,
  input  logic [WIDTH-1:0] pspOe,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPullupEn,
  output logic             ttlSel
);
  localparam int LAST = SYNC_LEN - 1;

  logic [WIDTH-1:0] latReg;
  logic [WIDTH-1:0] dirReg;
  logic             puEn;
  logic [WIDTH-1:0] syncStage [SYNC_LEN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latReg <= '0;
      dirReg <= '1;
      puEn   <= 1'b1;
    end else begin
      if (stb.wrLat) latReg <= busWrData;
      if (stb.wrDir) dirReg <= busWrData;
      if (stb.wrCfg) puEn   <= busWrData[0];
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_LEN; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= padIn;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    if (stb.selExt) begin
      padOut = extOut;
      padOe  = extOe;
    end else if (stb.selPsp) begin
      padOut = pspOut;
      padOe  = pspOe;
    end else begin
      padOut = latReg;
      padOe  = ~dirReg;
    end
    padPullupEn = puEn ? ~padOe : '0;
    ttlSel      = stb.selPsp;
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_PORT: busRdData = syncStage[LAST];
      RD_LAT:  busRdData = latReg;
      RD_DIR:  busRdData = dirReg;
      default: busRdData = {{(WIDTH-1){1'b0}}, puEn};
    endcase
  end
endmodule

// File: rtl/bport.sv
module bport
  import bport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic              extBusEn,
  input  logic [WIDTH-1:0]  extOut,
  input  logic [WIDTH-1:0]  extOe,
  input  logic              pspMode,
  input  logic [WIDTH-1:0]  pspOut,
  input  logic [WIDTH-1:0]  pspOe,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padPullupEn,
  output logic              ttlSel
);
  strobe_t stb;

  bport_ctrl u_ctrl (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .extBusEn (extBusEn),
    .pspMode  (pspMode),
    .stb      (stb)
  );

  bport_dpath #(.WIDTH(WIDTH), .SYNC_LEN(2)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .extOut      (extOut),
    .extOe       (extOe),
    .pspOut      (pspOut),
    .pspOe       (pspOe),
    .padIn       (padIn),
    .padOut      (padOut),
    .padOe       (padOe),
    .padPullupEn (padPullupEn),
    .ttlSel      (ttlSel)
  );
endmodule

// File: rtl/bport_chk.sv
module bport_chk
  import bport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [WIDTH-1:0]  busWrData,
  input logic [WIDTH-1:0]  busRdData,
  input logic              extBusEn,
  input logic [WIDTH-1:0]  extOut,
  input logic [WIDTH-1:0]  extOe,
  input logic              pspMode,
  input logic [WIDTH-1:0]  pspOut,
  input logic [WIDTH-1:0]  pspOe,
  input logic [WIDTH-1:0]  padIn,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padPullupEn,
  input logic              ttlSel
);
  logic [1:0] liveCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveCnt <= '0;
    else if (liveCnt != 2'd3) liveCnt <= liveCnt + 2'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt == 2'd0) |-> (extBusEn || pspMode || (padOe == '0 && padPullupEn == '1)));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_DIR) |=> (extBusEn || pspMode || padOe == ~$past(busWrData)));

  // R4
  port_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt >= 2'd2 && busAddr == REG_PORT) |-> busRdData == $past(padIn, 2));

  // R7
  pullup_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padPullupEn & padOe) == '0);

  // R8
  ext_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    extBusEn |-> (padOut == extOut && padOe == extOe));

  // R9
  psp_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pspMode && !extBusEn) |-> (padOut == pspOut && padOe == pspOe));

  // R10
  ttl_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    ttlSel == (pspMode && !extBusEn));
endmodule

bind bport bport_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_bport.sv
module test_bport;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 0;
  logic         rstN = 0;
  logic [1:0]   busAddr = 0;
  logic         busWrEn = 0;
  logic [W-1:0] busWrData = 0;
  logic [W-1:0] busRdData;
  logic         extBusEn = 0;
  logic [W-1:0] extOut = 0, extOe = 0;
  logic         pspMode = 0;
  logic [W-1:0] pspOut = 0, pspOe = 0;
  logic [W-1:0] padIn = 0;
  logic [W-1:0] padOut, padOe, padPullupEn;
  logic         ttlSel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bport #(.WIDTH(W)) i_bport (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [W-1:0] mLat, mDir, mS1, mS2;
  logic         mPu;

  always @(posedge clk) begin
    if (!rstN) begin
      mLat = 0; mDir = '1; mPu = 1; mS1 = 0; mS2 = 0;
    end else begin
      mS2 = mS1;
      mS1 = padIn;
      if (busWrEn) begin
        case (busAddr)
          2'd0, 2'd1: mLat = busWrData;
          2'd2:       mDir = busWrData;
          default:    mPu  = busWrData[0];
        endcase
      end
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [W-1:0] eOut, eOe, ePu, eRd;
      string own;
      if (extBusEn) begin eOut = extOut; eOe = extOe; own = "R8"; end
      else if (pspMode) begin eOut = pspOut; eOe = pspOe; own = "R9"; end
      else begin eOut = mLat; eOe = ~mDir; own = "R2"; end
      ePu = mPu ? ~eOe : '0;
      case (busAddr)
        2'd0: eRd = mS2;
        2'd1: eRd = mLat;
        2'd2: eRd = mDir;
        default: eRd = {7'd0, mPu};
      endcase
      check({own, " padOut"}, padOut, eOut);
      check({own, " padOe"}, padOe, eOe);
      check("R7 padPullupEn", padPullupEn, ePu);
      check("R10 ttlSel", {7'd0, ttlSel}, {7'd0, (pspMode && !extBusEn)});
      check(busAddr == 0 ? "R4 read" : busAddr == 1 ? "R3 read" : "R11 read", busRdData, eRd);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    busAddr = a; busWrData = d; busWrEn = 1;
    step(1);
    busWrEn = 0;
  endtask

  task automatic rdChk(string req, logic [1:0] a, logic [W-1:0] exp);
    busAddr = a;
    #1;
    check(req, busRdData, exp);
  endtask

  task automatic summary;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
  end

  initial begin
    step(3);
    rstN = 1;
    step(1);
    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    check("R1 padPullupEn", padPullupEn, 8'hFF);
    rdChk("R1 latch", 2'd1, 8'h00);
    rdChk("R1 dir", 2'd2, 8'hFF);

    // R2 drive latch onto output pins
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'hCF);
    check("R2 padOe", padOe, 8'h30);
    check("R2 padOut", padOut, 8'hA5);
    check("R7 pull-ups on inputs only", padPullupEn, 8'hCF);
    rdChk("R11 dir readback", 2'd2, 8'hCF);

    // R3 latch readback differs from pins
    padIn = 8'h5A;
    step(3);
    rdChk("R3 latch not pins", 2'd1, 8'hA5);
    // R4 synchronized pin read
    rdChk("R4 port read", 2'd0, 8'h5A);
    for (int i = 0; i < 6; i++) begin
      padIn = 8'h11 * i[7:0] ^ 8'h3C;
      step(1);
    end
    step(2);
    rdChk("R4 port read pattern", 2'd0, 8'h11 * 8'd5 ^ 8'h3C);

    // R5 port write lands in latch
    wr(2'd0, 8'h3C);
    rdChk("R5 latch after port write", 2'd1, 8'h3C);
    check("R5 padOut", padOut, 8'h3C);

    // R6 global pull-up clear and set
    wr(2'd3, 8'hFE);
    check("R6 pull-ups off", padPullupEn, 8'h00);
    rdChk("R11 cfg readback", 2'd3, 8'h00);
    wr(2'd3, 8'h01);
    check("R6 pull-ups on", padPullupEn, 8'hCF);
    rdChk("R11 cfg readback set", 2'd3, 8'h01);

    // R9 and R10 parallel port ownership
    pspMode = 1; pspOut = 8'h96; pspOe = 8'h0F;
    #1;
    check("R9 padOut", padOut, 8'h96);
    check("R9 padOe", padOe, 8'h0F);
    check("R10 ttl", {7'd0, ttlSel}, 8'h01);
    check("R7 psp pull-ups", padPullupEn, 8'hF0);
    step(2);

    // R8 external bus over parallel port and GPIO
    extBusEn = 1; extOut = 8'h69; extOe = 8'hFF;
    #1;
    check("R8 padOut", padOut, 8'h69);
    check("R8 padOe", padOe, 8'hFF);
    check("R10 ttl off", {7'd0, ttlSel}, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    check("R8 GPIO writes no effect", padOut, 8'h69);
    extOe = 8'h00;
    step(1);
    check("R8 padOe follows bus", padOe, 8'h00);
    extBusEn = 0; pspMode = 0;
    #1;
    check("R2 GPIO back, all outputs", padOe, 8'hFF);
    check("R7 no pull-ups on outputs", padPullupEn, 8'h00);

    // R1 second reset
    rstN = 0;
    step(2);
    rstN = 1;
    step(1);
    check("R1 padOe after reset", padOe, 8'h00);
    check("R1 pull-ups after reset", padPullupEn, 8'hFF);
    rdChk("R1 latch after reset", 2'd1, 8'h00);
    step(2);
    summary();
  end
endmodule